// File: doc/BRIEF.md
# Rotate, Shift and Nibble-Rotate Unit

This block is the bit-movement slice of an 8-bit processor datapath. It does three things:

- moves the bits of one operand byte left or right, as a circular rotate, a rotate through the carry, or a shift;
- swaps 4-bit digits across an accumulator and a memory byte, which is the packed-BCD rotate;
- keeps the flag byte that describes the outcome.

The operand byte and the accumulator come in from surrounding logic that fetches them and writes results back. The new data appears on the outputs in the same cycle as the inputs, because that path is purely combinational. The flag byte lives in a register inside the block. It takes its new value at the clock edge where `op_valid` is high. The carry that rotates use as their input is the carry bit of that register.

Four modes are selected by `op_mode`:

| `op_mode` | Mode | Effect |
|---|---|---|
| 0 | full | A rotate or shift on any operand, updating every flag. |
| 1 | accumulator short form | The same rotate, but only carry, half-carry and add/subtract are written. |
| 2 | digit-left | Nibble rotate to the left across the two bytes. |
| 3 | digit-right | Nibble rotate to the right across the two bytes. |

In the full and short forms, the kind of rotate or shift is picked by `op_sel`, the 3-bit field of the prefixed opcode.

Top module: `rsd_unit`

## Requirements
- R1: With `op_sel`=0 (circular left), the result is the operand moved up one place with old bit 7 in bit 0, and the new carry is old bit 7. With `op_sel`=1 (circular right), old bit 0 goes to both bit 7 and the carry.
- R2: With `op_sel`=2 (left through carry), the stored carry enters bit 0 and old bit 7 becomes the new carry. With `op_sel`=3 (right through carry), the stored carry enters bit 7 and old bit 0 becomes the new carry.
- R3: With `op_sel`=4, 6 and 7 the operand is shifted with a fill bit, and the bit shifted out becomes the new carry:
  - 4 and 6 shift left and fill bit 0 with 0;
  - 7 shifts right and fills bit 7 with 0.

  With `op_sel`=5 the operand shifts right, bit 7 keeps its value, and the bit shifted out becomes the new carry.
- R4: In full mode (`op_mode`=0) the flag byte is updated as follows:
  - carry takes the bit shifted out;
  - half-carry and add/subtract are cleared;
  - parity/overflow is 1 when the result has an even number of ones;
  - zero is 1 when the result is 0x00;
  - sign copies result bit 7.
- R5: In short-form mode (`op_mode`=1) the result and carry are as in full mode, and half-carry and add/subtract are cleared. Sign, zero and parity/overflow keep their previous values.
- R6: In digit-left mode (`op_mode`=2), with memory byte M on `operand` and accumulator A on `acc_in`:
  - `result` = {M[3:0], A[3:0]};
  - `acc_out` = {A[7:4], M[7:4]}.
- R7: In digit-right mode (`op_mode`=3):
  - `result` = {A[3:0], M[7:4]};
  - `acc_out` = {A[7:4], M[3:0]}.

  In every mode other than the digit rotates, `acc_out` equals `acc_in`.
- R8: In both digit modes:
  - carry is kept;
  - half-carry and add/subtract are cleared;
  - sign, zero and parity/overflow are taken from the new accumulator.
- R9: The flag byte is laid out as follows, and when `op_valid` is low it does not change:

  | Bit | Flag |
  |---|---|
  | 0 | carry |
  | 1 | add/subtract |
  | 2 | parity/overflow |
  | 3 | unused, always reads 0 |
  | 4 | half-carry |
  | 5 | unused, always reads 0 |
  | 6 | zero |
  | 7 | sign |

- R10: While `rst_n` is low, the flag byte is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of the flag register |
| op_valid | input | 1 | Update the flag register at this edge |
| op_mode | input | 2 | 0 full, 1 short form, 2 digit-left, 3 digit-right |
| op_sel | input | 3 | Rotate or shift kind (opcode bits 5:3) |
| operand | input | 8 | Operand byte, or the memory byte for digit modes |
| acc_in | input | 8 | Current accumulator |
| result | output | 8 | Rotated or shifted byte, or the new memory byte |
| acc_out | output | 8 | New accumulator |
| flags_q | output | 8 | Registered flag byte |

## Verification
The bench sets the carry through earlier operations and then runs the through-carry rotates with the carry at both 0 and 1. A design that used a constant in place of the stored carry would fail there.

Arithmetic right shift is applied to operands with bit 7 set, which separates it from the logical right shift. The fill-bit cases, all-zero results, and odd/even parity results expose a parity flag of the wrong sense or a stale zero flag.

The short form is run right after full operations that left sign and zero set, so a short form that rewrote those flags is caught. The digit rotates use distinct nibbles in all four positions, so a swapped nibble route or a changed accumulator high nibble shows up.

// File: rtl/rsd_pkg.sv
package rsd_pkg;

    // Operation class carried on op_mode
    typedef enum logic [1:0] {
        MODE_FULL  = 2'd0,
        MODE_ACC   = 2'd1,
        MODE_DIG_L = 2'd2,
        MODE_DIG_R = 2'd3
    } rsd_mode_e;

    // Shift/rotate kind selected by opcode field bits 5:3
    typedef enum logic [2:0] {
        SEL_RLC = 3'd0,
        SEL_RRC = 3'd1,
        SEL_RL  = 3'd2,
        SEL_RR  = 3'd3,
        SEL_SLA = 3'd4,
        SEL_SRA = 3'd5,
        SEL_SLX = 3'd6,
        SEL_SRL = 3'd7
    } rsd_sel_e;

    // Flag byte, MSB first: positions are decoded by neighbouring logic
    typedef struct packed {
        logic s;    // bit 7
        logic z;    // bit 6
        logic u5;   // bit 5, unused
        logic h;    // bit 4
        logic u3;   // bit 3, unused
        logic pv;   // bit 2
        logic n;    // bit 1
        logic c;    // bit 0
    } rsd_flags_t;

    localparam rsd_flags_t FLAGS_RESET = '0;

endpackage

// File: rtl/rsd_shifter.sv
module rsd_shifter
    import rsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  rsd_sel_e        sel,
    input  logic [DW-1:0]   din,
    input  logic            cin,
    output logic [DW-1:0]   dout,
    output logic            cout
);

    localparam int MSB = DW - 1;

    always_comb begin
        dout = din;
        cout = 1'b0;
        case (sel)
            SEL_RLC: begin
                dout = {din[MSB-1:0], din[MSB]};
                cout = din[MSB];
            end
            SEL_RRC: begin
                dout = {din[0], din[MSB:1]};
                cout = din[0];
            end
            SEL_RL: begin
                dout = {din[MSB-1:0], cin};
                cout = din[MSB];
            end
            SEL_RR: begin
                dout = {cin, din[MSB:1]};
                cout = din[0];
            end
            SEL_SLA, SEL_SLX: begin
                dout = {din[MSB-1:0], 1'b0};
                cout = din[MSB];
            end
            SEL_SRA: begin
                dout = {din[MSB], din[MSB:1]};
                cout = din[0];
            end
            SEL_SRL: begin
                dout = {1'b0, din[MSB:1]};
                cout = din[0];
            end
            default: begin
                dout = din;
                cout = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rsd_digit.sv
module rsd_digit #(
    parameter int DW = 8
) (
    input  logic            go_left,
    input  logic [DW-1:0]   mem_in,
    input  logic [DW-1:0]   acc_in,
    output logic [DW-1:0]   mem_out,
    output logic [DW-1:0]   acc_out
);

    localparam int NIB = DW / 2;

    logic [NIB-1:0] m_hi, m_lo, a_hi, a_lo;

    always_comb begin
        m_hi = mem_in[DW-1:NIB];
        m_lo = mem_in[NIB-1:0];
        a_hi = acc_in[DW-1:NIB];
        a_lo = acc_in[NIB-1:0];
        if (go_left) begin
            mem_out = {m_lo, a_lo};
            acc_out = {a_hi, m_hi};
        end else begin
            mem_out = {a_lo, m_hi};
            acc_out = {a_hi, m_lo};
        end
    end

endmodule

// File: rtl/rsd_flags.sv
module rsd_flags
    import rsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            valid,
    input  rsd_mode_e       mode,
    input  logic [DW-1:0]   shift_res,
    input  logic            shift_cout,
    input  logic [DW-1:0]   dig_acc,
    output rsd_flags_t      flags_q
);

    rsd_flags_t flags_d;

    always_comb begin
        flags_d = flags_q;
        if (valid) begin
            flags_d.u5 = 1'b0;
            flags_d.u3 = 1'b0;
            flags_d.h  = 1'b0;
            flags_d.n  = 1'b0;
            case (mode)
                MODE_FULL: begin
                    flags_d.c  = shift_cout;
                    flags_d.s  = shift_res[DW-1];
                    flags_d.z  = (shift_res == '0);
                    flags_d.pv = ~^shift_res;
                end
                MODE_ACC: begin
                    flags_d.c  = shift_cout;
                end
                MODE_DIG_L, MODE_DIG_R: begin
                    flags_d.s  = dig_acc[DW-1];
                    flags_d.z  = (dig_acc == '0);
                    flags_d.pv = ~^dig_acc;
                end
                default: flags_d = flags_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= FLAGS_RESET;
        else        flags_q <= flags_d;
    end

    // R4: full operations clear half-carry and add/subtract
    a_r4_full_clears_hn: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == MODE_FULL) |=> (!flags_q.h && !flags_q.n));

    // R5: short form keeps sign, zero and parity
    a_r5_short_keeps_szp: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && mode == MODE_ACC) |=>
            ({flags_q.s, flags_q.z, flags_q.pv} == $past({flags_q.s, flags_q.z, flags_q.pv})));

    // R8: digit rotates keep the carry
    a_r8_digit_keeps_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (mode == MODE_DIG_L || mode == MODE_DIG_R)) |=> (flags_q.c == $past(flags_q.c)));

    // R9: idle cycles hold the flag byte
    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> $stable(flags_q));

    // R9: unused flag positions stay clear
    a_r9_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags_q.u5 && !flags_q.u3));

endmodule

// File: rtl/rsd_unit.sv
module rsd_unit
    import rsd_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [1:0]      op_mode,
    input  logic [2:0]      op_sel,
    input  logic [DW-1:0]   operand,
    input  logic [DW-1:0]   acc_in,
    output logic [DW-1:0]   result,
    output logic [DW-1:0]   acc_out,
    output logic [7:0]      flags_q
);

    rsd_mode_e      mode;
    rsd_sel_e       sel;
    rsd_flags_t     flags_r;
    logic [DW-1:0]  sh_res, dg_mem, dg_acc;
    logic           sh_cout;
    logic           is_digit;

    assign mode     = rsd_mode_e'(op_mode);
    assign sel      = rsd_sel_e'(op_sel);
    assign is_digit = (mode == MODE_DIG_L) || (mode == MODE_DIG_R);

    rsd_shifter #(.DW(DW)) shifter_i (
        .sel  (sel),
        .din  (operand),
        .cin  (flags_r.c),
        .dout (sh_res),
        .cout (sh_cout)
    );

    rsd_digit #(.DW(DW)) digit_i (
        .go_left (mode == MODE_DIG_L),
        .mem_in  (operand),
        .acc_in  (acc_in),
        .mem_out (dg_mem),
        .acc_out (dg_acc)
    );

    rsd_flags #(.DW(DW)) flags_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .valid      (op_valid),
        .mode       (mode),
        .shift_res  (sh_res),
        .shift_cout (sh_cout),
        .dig_acc    (dg_acc),
        .flags_q    (flags_r)
    );

    always_comb begin
        result  = is_digit ? dg_mem : sh_res;
        acc_out = is_digit ? dg_acc : acc_in;
        flags_q = flags_r;
    end

endmodule

// File: tb/rsd_unit_tb_top.sv
module rsd_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [1:0] op_mode = 2'd0;
    logic [2:0] op_sel = 3'd0;
    logic [7:0] operand = 8'h00;
    logic [7:0] acc_in = 8'h00;
    logic [7:0] result, acc_out, flags_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 1'b0;
    logic [7:0] mflags = 8'h00;

    always #2 clk = ~clk;

    rsd_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_mode(op_mode),
        .op_sel(op_sel), .operand(operand), .acc_in(acc_in),
        .result(result), .acc_out(acc_out), .flags_q(flags_q)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    // Reference behaviour written from the requirements
    task automatic apply(input logic [1:0] md, input logic [2:0] sl, input logic [7:0] opd,
                         input logic [7:0] acc, input logic vld, input string tag);
        logic [7:0] er, ea, nf;
        logic ec, ci;
        ci = mflags[0];
        er = opd; ec = 1'b0; ea = acc;
        case (sl)
            3'd0: begin er = {opd[6:0], opd[7]}; ec = opd[7]; end
            3'd1: begin er = {opd[0], opd[7:1]}; ec = opd[0]; end
            3'd2: begin er = {opd[6:0], ci};     ec = opd[7]; end
            3'd3: begin er = {ci, opd[7:1]};     ec = opd[0]; end
            3'd4, 3'd6: begin er = {opd[6:0], 1'b0}; ec = opd[7]; end
            3'd5: begin er = {opd[7], opd[7:1]}; ec = opd[0]; end
            default: begin er = {1'b0, opd[7:1]}; ec = opd[0]; end
        endcase
        if (md == 2'd2) begin er = {opd[3:0], acc[3:0]}; ea = {acc[7:4], opd[7:4]}; end
        if (md == 2'd3) begin er = {acc[3:0], opd[7:4]}; ea = {acc[7:4], opd[3:0]}; end
        case (md)
            2'd0:    nf = {er[7], er == 8'h00, 1'b0, 1'b0, 1'b0, ~^er, 1'b0, ec};
            2'd1:    nf = {mflags[7], mflags[6], 1'b0, 1'b0, 1'b0, mflags[2], 1'b0, ec};
            default: nf = {ea[7], ea == 8'h00, 1'b0, 1'b0, 1'b0, ~^ea, 1'b0, mflags[0]};
        endcase
        op_mode = md; op_sel = sl; operand = opd; acc_in = acc; op_valid = vld;
        #1;
        check({tag, " result"}, result, er);
        check({tag, " acc_out"}, acc_out, ea);
        @(posedge clk); #1;
        if (vld) mflags = nf;
        check({tag, " flags"}, flags_q, mflags);
        op_valid = 1'b0;
    endtask

    task automatic t_reset();
        check("R10 reset flags", flags_q, 8'h00);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R10 flags after release", flags_q, 8'h00);
    endtask

    task automatic t_circular();
        apply(2'd0, 3'd0, 8'h81, 8'h00, 1'b1, "R1 rlc 81");
        check("R1 rlc 81 known", result, 8'h03);
        apply(2'd0, 3'd0, 8'h40, 8'h00, 1'b1, "R1 rlc 40");
        apply(2'd0, 3'd1, 8'h01, 8'h00, 1'b1, "R1 rrc 01");
        apply(2'd0, 3'd1, 8'h00, 8'h00, 1'b1, "R4 rrc zero");
    endtask

    task automatic t_through_carry();
        apply(2'd0, 3'd0, 8'h80, 8'h00, 1'b1, "R2 set carry");
        apply(2'd0, 3'd2, 8'h00, 8'h00, 1'b1, "R2 rl carry in 1");
        apply(2'd0, 3'd2, 8'h80, 8'h00, 1'b1, "R2 rl carry in 0");
        apply(2'd0, 3'd3, 8'h02, 8'h00, 1'b1, "R2 rr carry in 1");
        apply(2'd0, 3'd3, 8'h55, 8'h00, 1'b1, "R2 rr carry in 0");
    endtask

    task automatic t_shifts();
        apply(2'd0, 3'd4, 8'hC3, 8'h00, 1'b1, "R3 sla");
        apply(2'd0, 3'd6, 8'h7F, 8'h00, 1'b1, "R3 sel6 left");
        apply(2'd0, 3'd5, 8'h81, 8'h00, 1'b1, "R3 sra neg");
        check("R3 sra known", result, 8'hC0);
        apply(2'd0, 3'd7, 8'h81, 8'h00, 1'b1, "R3 srl");
        check("R3 srl known", result, 8'h40);
        apply(2'd0, 3'd7, 8'h01, 8'h00, 1'b1, "R4 srl to zero");
    endtask

    task automatic t_short_form();
        apply(2'd0, 3'd5, 8'h80, 8'h00, 1'b1, "R4 sign set");
        apply(2'd1, 3'd0, 8'h01, 8'h00, 1'b1, "R5 short rlc");
        apply(2'd0, 3'd7, 8'h01, 8'h00, 1'b1, "R4 zero set");
        apply(2'd1, 3'd3, 8'h01, 8'h00, 1'b1, "R5 short rr");
        apply(2'd1, 3'd2, 8'hFF, 8'h00, 1'b1, "R5 short rl");
    endtask

    task automatic t_digits();
        apply(2'd0, 3'd0, 8'h80, 8'h00, 1'b1, "R8 carry prep");
        apply(2'd2, 3'd0, 8'h34, 8'h12, 1'b1, "R6 digit left");
        check("R6 mem known", result, 8'h42);
        check("R6 acc known", acc_out, 8'h13);
        apply(2'd3, 3'd0, 8'h34, 8'h12, 1'b1, "R7 digit right");
        check("R7 mem known", result, 8'h23);
        check("R7 acc known", acc_out, 8'h14);
        apply(2'd2, 3'd0, 8'h0A, 8'h09, 1'b1, "R8 digit zero acc");
        apply(2'd3, 3'd0, 8'hB7, 8'hE5, 1'b1, "R8 digit neg acc");
    endtask

    task automatic t_idle();
        apply(2'd0, 3'd0, 8'h80, 8'h00, 1'b1, "R9 prep");
        apply(2'd0, 3'd7, 8'h00, 8'h00, 1'b0, "R9 idle full");
        apply(2'd3, 3'd0, 8'h00, 8'h00, 1'b0, "R9 idle digit");
        check("R9 unused bits", flags_q & 8'h28, 8'h00);
    endtask

    initial begin
        #1;
        t_reset();
        t_circular();
        t_through_carry();
        t_shifts();
        t_short_form();
        t_digits();
        t_idle();
        finished = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        #800000;
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule